// File: doc/BRIEF.md
# Two-Stage Partitioned Prefix Lookup

This block resolves a destination key to a next hop by longest-prefix matching, while comparing only a small slice of its rule store on each lookup. A small index table of ternary entries is searched first. The winning index row yields a descriptor made of a base row and a length. That descriptor selects one contiguous partition of a larger ternary data table. Only the rows inside that partition take part in the second compare. The winning data row then picks a next hop from a parallel hop table.

Partitions are laid out offline, so that each index entry covers every prefix stored in its partition. Within each table, entries are stored longest prefix first, and the lowest matching row wins. Besides the hop and a hit flag, each result carries a compare count. The count is the number of index rows plus the number of partition rows that were enabled. It serves as a proxy for search energy, which ideally grows near 2·sqrt(n) instead of n. The two stages are pipelined: one lookup is accepted per cycle, and its result appears two clock edges later. Both tables are loaded through plain single-row write ports.

Top module: `itcam_lookup`

## Requirements
- R1: After reset, res_valid is 0 and every entry of both tables is invalid, so any lookup reports a miss.
- R2: A request sampled at clock edge k gives res_valid high after edge k+2. Back-to-back requests give results in consecutive cycles, in request order.
- R3: The index stage picks the lowest-numbered valid index row that matches. Its stored base and length define the partition used.
- R4: Only data rows base through base+length-1 are compared. A matching data row outside that window never wins.
- R5: Among the matching rows of the partition, the lowest-numbered row wins, and res_hop returns the hop stored at that row.
- R6: When no index row matches, res_hit is 0, res_hop is 0 and res_cnt equals IDX_ROWS.
- R7: When an index row matches but no row in its partition does, the result is a miss with res_hop 0.
- R8: On an index hit, res_cnt equals IDX_ROWS plus the stored partition length.
- R9: A key bit is compared only where the entry's care bit is 1; care bit 0 is a wildcard. Rows with the valid bit 0 never match. Prefixes are left-aligned at the key MSB.
- R10: A table write at edge k is seen by a request sampled at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request strobe |
| req_key | input | KEY_W | Key to look up |
| ix_wr_en | input | 1 | Index row write strobe |
| ix_wr_row | input | clog2(IDX_ROWS) | Index row to write |
| ix_wr_valid | input | 1 | Valid bit written to the index row |
| ix_wr_value | input | KEY_W | Index entry value |
| ix_wr_care | input | KEY_W | Index entry care mask (1 = compare) |
| ix_wr_base | input | clog2(DATA_ROWS) | Partition base row |
| ix_wr_len | input | clog2(DATA_ROWS+1) | Partition length in rows |
| dt_wr_en | input | 1 | Data row write strobe |
| dt_wr_row | input | clog2(DATA_ROWS) | Data row to write |
| dt_wr_valid | input | 1 | Valid bit written to the data row |
| dt_wr_value | input | KEY_W | Data entry value |
| dt_wr_care | input | KEY_W | Data entry care mask (1 = compare) |
| dt_wr_hop | input | HOP_W | Next hop stored with the data row |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | Lookup found a next hop |
| res_hop | output | HOP_W | Next hop, 0 on miss |
| res_cnt | output | clog2(IDX_ROWS+DATA_ROWS+1) | Rows compared for this lookup |

## Verification
The hardest case to reach from the ports is a row that matches the key but sits outside the chosen partition, while a longer prefix of the same key is excluded. The stimulus reaches it by rewriting one index descriptor so that its window skips the row that would win in a full-table search. It also points a descriptor at a partition that holds no match, so that an index hit turns into a data miss. Back-to-back requests with different keys then show that each partition window travels with its own lookup through the pipeline.

// File: rtl/itcam_pkg.sv
`timescale 1ns/1ps
package itcam_pkg;
    localparam int DEF_KEY_W     = 8;
    localparam int DEF_IDX_ROWS  = 4;
    localparam int DEF_DATA_ROWS = 16;
    localparam int DEF_HOP_W     = 8;

    // row-address width that stays legal for a single-row table
    function automatic int addr_w(input int rows);
        return (rows > 1) ? $clog2(rows) : 1;
    endfunction
endpackage

// File: rtl/prio_pick.sv
`timescale 1ns/1ps
module prio_pick #(
    parameter int N  = 4,
    parameter int IW = itcam_pkg::addr_w(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] first
);
    logic [N-1:0] grant;

    always_comb begin
        first = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) first = IW'(i);
        end
        any   = |req;
        grant = req & (~req + N'(1));
    end

    // lowest set request and the isolated-bit grant must agree (R5)
    always_comb begin
        assert_grant_onehot_R5: assert ($onehot0(grant));
        if (any) assert_first_lowest_R5: assert (grant[first]);
    end
endmodule

// File: rtl/tcam_match.sv
`timescale 1ns/1ps
module tcam_match #(
    parameter int ROWS   = 4,
    parameter int W      = 8,
    parameter int BASE_W = 2,
    parameter int LEN_W  = 3,
    parameter int IW     = itcam_pkg::addr_w(ROWS)
) (
    input  logic [ROWS-1:0][W-1:0] ent_val,
    input  logic [ROWS-1:0][W-1:0] ent_care,
    input  logic [ROWS-1:0]        ent_vld,
    input  logic [W-1:0]           key,
    input  logic [BASE_W-1:0]      win_base,
    input  logic [LEN_W-1:0]       win_len,
    output logic                   hit,
    output logic [IW-1:0]          row
);
    logic [ROWS-1:0] line;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic in_win;
        assign in_win  = (r >= int'(win_base)) && (r < int'(win_base) + int'(win_len));
        assign line[r] = ent_vld[r] && in_win && (((key ^ ent_val[r]) & ent_care[r]) == '0);
    end

    prio_pick #(.N(ROWS), .IW(IW)) u_pick (
        .req   (line),
        .any   (hit),
        .first (row)
    );

    // winner always lies inside the enabled window (R4)
    always_comb begin
        if (hit) assert_hit_in_window_R4:
            assert (int'(row) >= int'(win_base) && int'(row) < int'(win_base) + int'(win_len));
    end
endmodule

// File: rtl/itcam_lookup.sv
`timescale 1ns/1ps
module itcam_lookup #(
    parameter int KEY_W     = itcam_pkg::DEF_KEY_W,
    parameter int IDX_ROWS  = itcam_pkg::DEF_IDX_ROWS,
    parameter int DATA_ROWS = itcam_pkg::DEF_DATA_ROWS,
    parameter int HOP_W     = itcam_pkg::DEF_HOP_W,
    localparam int IXW      = itcam_pkg::addr_w(IDX_ROWS),
    localparam int DXW      = itcam_pkg::addr_w(DATA_ROWS),
    localparam int LEN_W    = $clog2(DATA_ROWS + 1),
    localparam int CNT_W    = $clog2(IDX_ROWS + DATA_ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [KEY_W-1:0] req_key,
    input  logic             ix_wr_en,
    input  logic [IXW-1:0]   ix_wr_row,
    input  logic             ix_wr_valid,
    input  logic [KEY_W-1:0] ix_wr_value,
    input  logic [KEY_W-1:0] ix_wr_care,
    input  logic [DXW-1:0]   ix_wr_base,
    input  logic [LEN_W-1:0] ix_wr_len,
    input  logic             dt_wr_en,
    input  logic [DXW-1:0]   dt_wr_row,
    input  logic             dt_wr_valid,
    input  logic [KEY_W-1:0] dt_wr_value,
    input  logic [KEY_W-1:0] dt_wr_care,
    input  logic [HOP_W-1:0] dt_wr_hop,
    output logic             res_valid,
    output logic             res_hit,
    output logic [HOP_W-1:0] res_hop,
    output logic [CNT_W-1:0] res_cnt
);
    localparam int IXL_W = $clog2(IDX_ROWS + 1);

    typedef struct packed {
        logic [IDX_ROWS-1:0]             ix_vld;
        logic [IDX_ROWS-1:0][KEY_W-1:0]  ix_val;
        logic [IDX_ROWS-1:0][KEY_W-1:0]  ix_care;
        logic [IDX_ROWS-1:0][DXW-1:0]    ix_base;
        logic [IDX_ROWS-1:0][LEN_W-1:0]  ix_len;
        logic [DATA_ROWS-1:0]            dt_vld;
        logic [DATA_ROWS-1:0][KEY_W-1:0] dt_val;
        logic [DATA_ROWS-1:0][KEY_W-1:0] dt_care;
        logic [DATA_ROWS-1:0][HOP_W-1:0] dt_hop;
        logic                            s1_valid;
        logic [KEY_W-1:0]                s1_key;
        logic                            s1_ihit;
        logic [DXW-1:0]                  s1_base;
        logic [LEN_W-1:0]                s1_len;
        logic                            o_valid;
        logic                            o_hit;
        logic [HOP_W-1:0]                o_hop;
        logic [CNT_W-1:0]                o_cnt;
    } state_t;

    state_t st_d, st_q;

    logic           ix_hit, dt_hit;
    logic [IXW-1:0] ix_row;
    logic [DXW-1:0] dt_row;
    logic [LEN_W-1:0] dt_len;

    // stage 1: whole index table, always enabled
    tcam_match #(.ROWS(IDX_ROWS), .W(KEY_W), .BASE_W(1), .LEN_W(IXL_W), .IW(IXW)) u_ix (
        .ent_val  (st_q.ix_val),
        .ent_care (st_q.ix_care),
        .ent_vld  (st_q.ix_vld),
        .key      (req_key),
        .win_base (1'b0),
        .win_len  (IXL_W'(IDX_ROWS)),
        .hit      (ix_hit),
        .row      (ix_row)
    );

    // stage 2: only the partition named by the index descriptor
    assign dt_len = st_q.s1_ihit ? st_q.s1_len : '0;

    tcam_match #(.ROWS(DATA_ROWS), .W(KEY_W), .BASE_W(DXW), .LEN_W(LEN_W), .IW(DXW)) u_dt (
        .ent_val  (st_q.dt_val),
        .ent_care (st_q.dt_care),
        .ent_vld  (st_q.dt_vld),
        .key      (st_q.s1_key),
        .win_base (st_q.s1_base),
        .win_len  (dt_len),
        .hit      (dt_hit),
        .row      (dt_row)
    );

    always_comb begin
        st_d = st_q;
        if (ix_wr_en) begin
            st_d.ix_vld[ix_wr_row]  = ix_wr_valid;
            st_d.ix_val[ix_wr_row]  = ix_wr_value;
            st_d.ix_care[ix_wr_row] = ix_wr_care;
            st_d.ix_base[ix_wr_row] = ix_wr_base;
            st_d.ix_len[ix_wr_row]  = ix_wr_len;
        end
        if (dt_wr_en) begin
            st_d.dt_vld[dt_wr_row]  = dt_wr_valid;
            st_d.dt_val[dt_wr_row]  = dt_wr_value;
            st_d.dt_care[dt_wr_row] = dt_wr_care;
            st_d.dt_hop[dt_wr_row]  = dt_wr_hop;
        end
        st_d.s1_valid = req_valid;
        st_d.s1_key   = req_key;
        st_d.s1_ihit  = req_valid && ix_hit;
        st_d.s1_base  = st_q.ix_base[ix_row];
        st_d.s1_len   = st_q.ix_len[ix_row];
        st_d.o_valid  = st_q.s1_valid;
        st_d.o_hit    = st_q.s1_valid && st_q.s1_ihit && dt_hit;
        st_d.o_hop    = st_d.o_hit ? st_q.dt_hop[dt_row] : '0;
        st_d.o_cnt    = CNT_W'(IDX_ROWS) + (st_q.s1_ihit ? CNT_W'(st_q.s1_len) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_valid = st_q.o_valid;
    assign res_hit   = st_q.o_hit;
    assign res_hop   = st_q.o_hop;
    assign res_cnt   = st_q.o_cnt;

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid == ($past(req_valid && !rst, 2) && !$past(rst, 1)));
    assert_hit_needs_valid_R5: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> res_valid);
    assert_miss_hop_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> res_hop == '0);
    assert_cnt_floor_R8: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (int'(res_cnt) >= IDX_ROWS && int'(res_cnt) <= IDX_ROWS + DATA_ROWS));
endmodule

// File: tb/sim_itcam_lookup.sv
`timescale 1ns/1ps
module sim_itcam_lookup;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [7:0] req_key = '0;
    logic       ix_wr_en = 1'b0, ix_wr_valid = 1'b0;
    logic [1:0] ix_wr_row = '0;
    logic [7:0] ix_wr_value = '0, ix_wr_care = '0;
    logic [3:0] ix_wr_base = '0;
    logic [4:0] ix_wr_len = '0;
    logic       dt_wr_en = 1'b0, dt_wr_valid = 1'b0;
    logic [3:0] dt_wr_row = '0;
    logic [7:0] dt_wr_value = '0, dt_wr_care = '0, dt_wr_hop = '0;
    logic       res_valid, res_hit;
    logic [7:0] res_hop;
    logic [4:0] res_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    itcam_lookup u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_key(req_key),
        .ix_wr_en(ix_wr_en), .ix_wr_row(ix_wr_row), .ix_wr_valid(ix_wr_valid),
        .ix_wr_value(ix_wr_value), .ix_wr_care(ix_wr_care),
        .ix_wr_base(ix_wr_base), .ix_wr_len(ix_wr_len),
        .dt_wr_en(dt_wr_en), .dt_wr_row(dt_wr_row), .dt_wr_valid(dt_wr_valid),
        .dt_wr_value(dt_wr_value), .dt_wr_care(dt_wr_care), .dt_wr_hop(dt_wr_hop),
        .res_valid(res_valid), .res_hit(res_hit), .res_hop(res_hop), .res_cnt(res_cnt)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one lookup; compares valid, hit, hop and count
    task automatic look(input string req, input logic [7:0] key,
                        input int hit, input int hop, input int cnt);
        @(negedge clk); req_valid = 1'b1; req_key = key;
        @(negedge clk); req_valid = 1'b0;
        check(req, "valid early", int'(res_valid), 0);
        @(negedge clk);
        check(req, "valid", int'(res_valid), 1);
        check(req, "hit", int'(res_hit), hit);
        check(req, "hop", int'(res_hop), hop);
        check(req, "cnt", int'(res_cnt), cnt);
    endtask

    task automatic wr_ix(input logic [1:0] row, input logic v, input logic [7:0] val,
                         input logic [7:0] care, input logic [3:0] base, input logic [4:0] len);
        @(negedge clk);
        ix_wr_en = 1'b1; ix_wr_row = row; ix_wr_valid = v; ix_wr_value = val;
        ix_wr_care = care; ix_wr_base = base; ix_wr_len = len;
        @(negedge clk); ix_wr_en = 1'b0;
    endtask

    task automatic wr_dt(input logic [3:0] row, input logic [7:0] val,
                         input logic [7:0] care, input logic [7:0] hop);
        @(negedge clk);
        dt_wr_en = 1'b1; dt_wr_row = row; dt_wr_valid = 1'b1; dt_wr_value = val;
        dt_wr_care = care; dt_wr_hop = hop;
        @(negedge clk); dt_wr_en = 1'b0;
    endtask

    task automatic t_reset;
        check("R1", "valid after reset", int'(res_valid), 0);
        look("R1", 8'h00, 0, 0, 4);
        look("R1", 8'hFF, 0, 0, 4);
    endtask

    task automatic t_load;
        // index: 00* -> (0,2), 0* -> (2,3), * -> (5,2)
        wr_ix(2'd0, 1'b1, 8'h00, 8'hC0, 4'd0, 5'd2);
        wr_ix(2'd1, 1'b1, 8'h00, 8'h80, 4'd2, 5'd3);
        wr_ix(2'd2, 1'b1, 8'h00, 8'h00, 4'd5, 5'd2);
        // data partitions {000*,00*} {011*,01*,0*} {11*,*}
        wr_dt(4'd0, 8'h00, 8'hE0, 8'hA1);
        wr_dt(4'd1, 8'h00, 8'hC0, 8'hA2);
        wr_dt(4'd2, 8'h60, 8'hE0, 8'hA3);
        wr_dt(4'd3, 8'h40, 8'hC0, 8'hA4);
        wr_dt(4'd4, 8'h00, 8'h80, 8'hA5);
        wr_dt(4'd5, 8'hC0, 8'hC0, 8'hA6);
        wr_dt(4'd6, 8'h00, 8'h00, 8'hA7);
    endtask

    task automatic t_basic;
        look("R3", 8'h05, 1, 'hA1, 6);   // 000.. : index row0, data row0
        look("R5", 8'h20, 1, 'hA2, 6);   // 001.. : only 00* in partition
        look("R3", 8'h61, 1, 'hA3, 7);   // 011.. : index row1
        look("R9", 8'h5F, 1, 'hA4, 7);   // 010.. : wildcard low bits
        look("R5", 8'h90, 1, 'hA7, 6);   // 100.. : * wins in last partition
        look("R8", 8'hC3, 1, 'hA6, 6);   // 11..  : 11* before *
    endtask

    task automatic t_window;
        // window (6,1) skips row5 although 11* matches
        wr_ix(2'd2, 1'b1, 8'h00, 8'h00, 4'd6, 5'd1);
        look("R4", 8'hC3, 1, 'hA7, 5);
    endtask

    task automatic t_data_miss;
        wr_ix(2'd2, 1'b1, 8'h00, 8'h00, 4'd0, 5'd2);
        look("R7", 8'hC3, 0, 0, 6);
    endtask

    task automatic t_index_miss;
        // invalidate the catch-all index row, then look up at once
        @(negedge clk);
        ix_wr_en = 1'b1; ix_wr_row = 2'd2; ix_wr_valid = 1'b0;
        @(negedge clk); ix_wr_en = 1'b0; req_valid = 1'b1; req_key = 8'hC3;
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        check("R10", "valid", int'(res_valid), 1);
        check("R10", "hit after invalidate", int'(res_hit), 0);
        check("R6", "hop", int'(res_hop), 0);
        check("R6", "cnt", int'(res_cnt), 4);
        look("R9", 8'h80, 0, 0, 4);
    endtask

    task automatic t_stream;
        @(negedge clk); req_valid = 1'b1; req_key = 8'h05;
        @(negedge clk); req_key = 8'h61;
        @(negedge clk); req_key = 8'hFF;
        check("R2", "stream a valid", int'(res_valid), 1);
        check("R2", "stream a hop", int'(res_hop), 'hA1);
        check("R2", "stream a cnt", int'(res_cnt), 6);
        @(negedge clk); req_valid = 1'b0;
        check("R2", "stream b valid", int'(res_valid), 1);
        check("R2", "stream b hop", int'(res_hop), 'hA3);
        check("R2", "stream b cnt", int'(res_cnt), 7);
        @(negedge clk);
        check("R2", "stream c valid", int'(res_valid), 1);
        check("R2", "stream c hit", int'(res_hit), 0);
        check("R2", "stream c cnt", int'(res_cnt), 4);
        @(negedge clk);
        check("R2", "stream idle", int'(res_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_basic();
        t_window();
        t_data_miss();
        t_index_miss();
        t_stream();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule